// File: doc/BRIEF.md
# Wear-Levelling Nonvolatile Event Counter

This block keeps an up-counter in a byte-wide nonvolatile memory that can erase a whole byte to zero and can set bits from 0 to 1 without an erase. The count lives in a small ring of storage bytes. Each byte fills as a thermometer code: the low-order bits are set one at a time, so one byte absorbs a full byte-width of increments for a single erase. Bytes are filled one after another in Gray order of their addresses, so successive byte selections differ in one address bit. No storage location takes every update the way the low bit of a binary counter would. A separate wrap word at the address just past the ring records how many times the whole ring has been filled.

At reset the block reads every ring byte and the wrap word, and it rebuilds the count as wrap × (bytes × bits per byte) plus the total number of set bits. It reports the count only after this scan. A one-cycle increment pulse can arrive at any time, including during the scan or while an earlier increment is still being written. Each pulse is queued and served in turn. The block issues read, program and erase commands on a simple request/acknowledge memory port. It gives a binary count, a busy flag and a one-cycle done pulse for each completed increment.

Top module: `wlc_counter`

## Requirements
- R1: After reset, count_valid is low and the block reads addresses 0 to NBYTES in ascending order with READ commands. The wrap word is at address NBYTES. count_valid then rises with count = wrap × NBYTES × BYTE_W + the total number of set bits in the ring bytes.
- R2: An increment advances the first byte, taken in position order p = 0, 1, … at address p ^ (p >> 1), whose value is not all ones.
- R3: If the selected byte holds a valid thermometer code (2^k − 1), the increment is one PROGRAM of (old << 1) | 1 to that address, with no erase. Exactly one stored bit changes.
- R4: If every ring byte is all ones, the increment runs in this order: it erases the wrap word, programs it with wrap + 1 (modulo 2^BYTE_W), erases each ring byte, then programs address 0 with 0x01.
- R5: If the selected byte is not a thermometer code and has k set bits, the increment erases that byte and then programs it with 2^(k+1) − 1.
- R6: count changes only in a cycle where done is high, and then by exactly +1 modulo 2^(BYTE_W + log2(NBYTES × BYTE_W)). done is high exactly once per served increment.
- R7: inc_req pulses that arrive during the scan or while busy are queued, up to 2^PEND_W − 1 outstanding. Each is served separately; none is dropped or merged.
- R8: mem_cmd encodes READ = 0, PROGRAM = 1, ERASE = 2. While mem_req is high and mem_ack is low, mem_cmd, mem_addr and mem_wdata hold steady. The addresses used are 0 to NBYTES.
- R9: The block never programs a value that would clear a stored bit that has not been erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the power-up scan |
| inc_req | input | 1 | One-cycle pulse per increment request |
| busy | output | 1 | High while scanning or executing an increment |
| done | output | 1 | One-cycle pulse when an increment is complete |
| count_valid | output | 1 | High once the scan has rebuilt the count |
| count | output | BYTE_W+log2(NBYTES*BYTE_W) | Decoded binary count |
| mem_req | output | 1 | Memory command request, held until acknowledged |
| mem_cmd | output | 2 | 0 READ, 1 PROGRAM, 2 ERASE |
| mem_addr | output | log2(NBYTES)+1 | Byte address; NBYTES is the wrap word |
| mem_wdata | output | BYTE_W | Program data |
| mem_rdata | input | BYTE_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge that completes the current command |

## Verification
On every cycle the assertions check the following. The memory command stays stable until acknowledged and uses only legal codes. Every ring-byte program carries a thermometer value. Reads occur only before count_valid. The count moves only with done, and then by one. The scenarios are needed for the rest. They show the Gray fill order, the exact bytes and wrap word after each step, the ordered wrap sequence, repair of a corrupted byte, the rebuilt count after a reset with memory kept, queueing during the scan and during bursts, and that no bit is ever cleared without an erase.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
   typedef enum logic [1:0] {
      MEM_READ  = 2'd0,
      MEM_PROG  = 2'd1,
      MEM_ERASE = 2'd2
   } mem_cmd_e;

   // position in the fill walk -> byte address
   function automatic int walk_addr(input int pos);
      return pos ^ (pos >> 1);
   endfunction
endpackage

// File: rtl/wlc_decode.sv
module wlc_decode #(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   parameter int GA_W   = $clog2(NBYTES),
   parameter int POP_W  = $clog2(BYTE_W + 1),
   parameter int SUM_W  = $clog2(NBYTES * BYTE_W + 1)
) (
   input  logic [NBYTES*BYTE_W-1:0] bytes_flat,
   output logic                     all_full,
   output logic [GA_W-1:0]          cur_addr,
   output logic [POP_W-1:0]         cur_pop,
   output logic                     cur_thermo,
   output logic [SUM_W-1:0]         pop_sum
);
   logic [POP_W-1:0] pop_v [NBYTES];
   logic [NBYTES-1:0] full_v;
   logic [NBYTES-1:0] therm_v;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      logic [BYTE_W-1:0] b;
      assign b          = bytes_flat[g*BYTE_W +: BYTE_W];
      assign pop_v[g]   = POP_W'($countones(b));
      assign full_v[g]  = &b;
      assign therm_v[g] = ((b & (b + 1'b1)) == '0);
   end

   always_comb begin
      pop_sum = '0;
      for (int i = 0; i < NBYTES; i++) pop_sum = pop_sum + SUM_W'(pop_v[i]);
      all_full = 1'b1;
      cur_addr = '0;
      for (int p = NBYTES - 1; p >= 0; p--) begin
         if (!full_v[wlc_pkg::walk_addr(p)]) begin
            all_full = 1'b0;
            cur_addr = GA_W'(wlc_pkg::walk_addr(p));
         end
      end
      cur_pop    = pop_v[cur_addr];
      cur_thermo = therm_v[cur_addr];
   end
endmodule

// File: rtl/wlc_pend.sv
module wlc_pend #(
   parameter int PEND_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic pop,
   output logic pending
);
   logic [PEND_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + PEND_W'(push) - PEND_W'(pop);
   end

   assign pending = (cnt_q != '0);
endmodule

// File: rtl/wlc_counter.sv
module wlc_counter #(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   parameter int PEND_W = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        inc_req,
   output logic                                        busy,
   output logic                                        done,
   output logic                                        count_valid,
   output logic [BYTE_W+$clog2(NBYTES*BYTE_W)-1:0]     count,
   output logic                                        mem_req,
   output logic [1:0]                                  mem_cmd,
   output logic [$clog2(NBYTES):0]                     mem_addr,
   output logic [BYTE_W-1:0]                           mem_wdata,
   input  logic [BYTE_W-1:0]                           mem_rdata,
   input  logic                                        mem_ack
);
   import wlc_pkg::*;

   localparam int GA_W   = $clog2(NBYTES);
   localparam int ADDR_W = GA_W + 1;
   localparam int POP_W  = $clog2(BYTE_W + 1);
   localparam int SUM_W  = $clog2(NBYTES * BYTE_W + 1);
   localparam int LOGCAP = $clog2(NBYTES * BYTE_W);
   localparam int CNT_W  = BYTE_W + LOGCAP;

   if (NBYTES < 2 || (NBYTES & (NBYTES - 1)) != 0 ||
       BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0 || PEND_W < 1) begin : g_param_bad
      $error("wlc_counter: NBYTES and BYTE_W must be powers of two >= 2, PEND_W >= 1");
   end

   typedef enum logic [2:0] {
      ST_SCAN, ST_IDLE, ST_ERASE_CUR, ST_PROG,
      ST_WRAP_ERASE, ST_WRAP_PROG, ST_CLEAR
   } state_e;

   function automatic logic [BYTE_W-1:0] thermo_of(input int k);
      logic [BYTE_W-1:0] t;
      for (int i = 0; i < BYTE_W; i++) t[i] = (i < k);
      return t;
   endfunction

   state_e              state_q;
   logic [ADDR_W-1:0]   idx_q;
   logic [GA_W-1:0]     tgt_addr_q;
   logic [BYTE_W-1:0]   tgt_data_q;
   logic [BYTE_W-1:0]   wrap_q;
   logic [BYTE_W-1:0]   shadow_q [NBYTES];
   logic [CNT_W-1:0]    count_q;
   logic                valid_q;
   logic                done_q;

   logic [NBYTES*BYTE_W-1:0] shadow_flat;
   for (genvar g = 0; g < NBYTES; g++) begin : g_flat
      assign shadow_flat[g*BYTE_W +: BYTE_W] = shadow_q[g];
   end

   logic             all_full, cur_thermo, pending, start;
   logic [GA_W-1:0]  cur_addr;
   logic [POP_W-1:0] cur_pop;
   logic [SUM_W-1:0] pop_sum;

   wlc_decode #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_decode (
      .bytes_flat (shadow_flat),
      .all_full   (all_full),
      .cur_addr   (cur_addr),
      .cur_pop    (cur_pop),
      .cur_thermo (cur_thermo),
      .pop_sum    (pop_sum)
   );

   assign start = (state_q == ST_IDLE) && pending;

   wlc_pend #(.PEND_W(PEND_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (inc_req),
      .pop     (start),
      .pending (pending)
   );

   always_comb begin
      mem_req   = (state_q != ST_IDLE);
      mem_cmd   = MEM_READ;
      mem_addr  = idx_q;
      mem_wdata = '0;
      unique case (state_q)
         ST_SCAN:       begin mem_cmd = MEM_READ;  mem_addr = idx_q; end
         ST_ERASE_CUR:  begin mem_cmd = MEM_ERASE; mem_addr = {1'b0, tgt_addr_q}; end
         ST_PROG:       begin mem_cmd = MEM_PROG;  mem_addr = {1'b0, tgt_addr_q};
                              mem_wdata = tgt_data_q; end
         ST_WRAP_ERASE: begin mem_cmd = MEM_ERASE; mem_addr = ADDR_W'(NBYTES); end
         ST_WRAP_PROG:  begin mem_cmd = MEM_PROG;  mem_addr = ADDR_W'(NBYTES);
                              mem_wdata = wrap_q + 1'b1; end
         ST_CLEAR:      begin mem_cmd = MEM_ERASE; mem_addr = idx_q; end
         default:       ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_SCAN;
         idx_q      <= '0;
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
         wrap_q     <= '0;
         count_q    <= '0;
         valid_q    <= 1'b0;
         done_q     <= 1'b0;
         for (int i = 0; i < NBYTES; i++) shadow_q[i] <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_SCAN: if (mem_ack) begin
               if (idx_q == ADDR_W'(NBYTES)) begin
                  wrap_q  <= mem_rdata;
                  count_q <= {mem_rdata, {LOGCAP{1'b0}}} + CNT_W'(pop_sum);
                  valid_q <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  shadow_q[idx_q[GA_W-1:0]] <= mem_rdata;
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_IDLE: if (start) begin
               if (all_full) begin
                  state_q <= ST_WRAP_ERASE;
               end else begin
                  tgt_addr_q <= cur_addr;
                  tgt_data_q <= thermo_of(int'(cur_pop) + 1);
                  state_q    <= cur_thermo ? ST_PROG : ST_ERASE_CUR;
               end
            end
            ST_ERASE_CUR: if (mem_ack) begin
               shadow_q[tgt_addr_q] <= '0;
               state_q <= ST_PROG;
            end
            ST_PROG: if (mem_ack) begin
               shadow_q[tgt_addr_q] <= tgt_data_q;
               count_q <= count_q + 1'b1;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_WRAP_ERASE: if (mem_ack) state_q <= ST_WRAP_PROG;
            ST_WRAP_PROG: if (mem_ack) begin
               wrap_q  <= wrap_q + 1'b1;
               idx_q   <= '0;
               state_q <= ST_CLEAR;
            end
            ST_CLEAR: if (mem_ack) begin
               shadow_q[idx_q[GA_W-1:0]] <= '0;
               idx_q <= idx_q + 1'b1;
               if (idx_q == ADDR_W'(NBYTES - 1)) begin
                  tgt_addr_q <= GA_W'(walk_addr(0));
                  tgt_data_q <= thermo_of(1);
                  state_q    <= ST_PROG;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign count_valid = valid_q;
   assign count       = count_q;
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = BYTE_W + $clog2(NBYTES * BYTE_W),
   parameter int ADDR_W = $clog2(NBYTES) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              count_valid,
   input logic [CNT_W-1:0]  count,
   input logic              mem_req,
   input logic [1:0]        mem_cmd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [BYTE_W-1:0] mem_wdata,
   input logic              mem_ack
);
   // R8: request held with stable fields until acknowledged
   a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_cmd) && $stable(mem_addr) && $stable(mem_wdata)));

   // R8: legal command code and address range
   a_r8_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_cmd != 2'd3 && mem_addr <= ADDR_W'(NBYTES)));

   // R3: every ring-byte program is a nonzero thermometer value
   a_r3_prog_thermo: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_cmd == 2'd1 && mem_addr < ADDR_W'(NBYTES))
         |-> (mem_wdata != '0 && ((mem_wdata & (mem_wdata + 1'b1)) == '0)));

   // R1: reads only happen during the power-up scan
   a_r1_read_only_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      count_valid |-> !(mem_req && mem_cmd == 2'd0));

   // R6: count moves only with done, and then by one
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count_valid && $past(count_valid))
         |-> (done ? (count == $past(count) + 1'b1) : (count == $past(count))));

   // R6: done never precedes a valid count
   a_r6_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> count_valid);
endmodule

bind wlc_counter wlc_checker #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .done        (done),
   .count_valid (count_valid),
   .count       (count),
   .mem_req     (mem_req),
   .mem_cmd     (mem_cmd),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ack     (mem_ack)
);

// File: tb/sim_wlc_counter.sv
`timescale 1ns/1ps
module sim_wlc_counter;
   localparam int NB    = 4;
   localparam int BW    = 8;
   localparam int CAP   = NB * BW;
   localparam int CNT_W = BW + $clog2(CAP);
   localparam int MODC  = 1 << CNT_W;

   logic clk = 1'b0, rst_n = 1'b0, inc_req = 1'b0;
   logic busy, done, count_valid, mem_req, mem_ack;
   logic [CNT_W-1:0] count;
   logic [1:0] mem_cmd;
   logic [$clog2(NB):0] mem_addr;
   logic [BW-1:0] mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   wlc_counter #(.NBYTES(NB), .BYTE_W(BW), .PEND_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .busy(busy), .done(done),
      .count_valid(count_valid), .count(count), .mem_req(mem_req), .mem_cmd(mem_cmd),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

   int total = 0, bad = 0;
   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [BW-1:0] mem [0:NB];
   int  erase_cnt [0:NB];
   bit  erased_since [0:NB];
   int  clear_viol = 0, multi_bit = 0, bad_cmd = 0;
   logic [BW-1:0] trace_d [$];
   int            trace_c [$];
   int            trace_a [$];

   initial begin
      for (int i = 0; i <= NB; i++) begin mem[i] = '0; erase_cnt[i] = 0; erased_since[i] = 1'b0; end
      mem_ack = 1'b0; mem_rdata = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_addr > NB || mem_cmd == 2'd3) bad_cmd++;
         else begin
            trace_c.push_back(int'(mem_cmd)); trace_a.push_back(int'(mem_addr)); trace_d.push_back(mem_wdata);
            case (mem_cmd)
               2'd0: mem_rdata <= mem[mem_addr];
               2'd1: begin
                  if ((mem[mem_addr] & ~mem_wdata) != '0) clear_viol++;
                  if (mem_addr < NB && !erased_since[mem_addr] &&
                      $countones(mem[mem_addr] ^ mem_wdata) != 1) multi_bit++;
                  mem[mem_addr] = mem[mem_addr] | mem_wdata;
                  erased_since[mem_addr] = 1'b0;
               end
               2'd2: begin
                  mem[mem_addr] = '0;
                  erase_cnt[mem_addr]++;
                  erased_since[mem_addr] = 1'b1;
               end
               default: ;
            endcase
         end
      end else mem_ack <= 1'b0;
   end

   // ---------------- reference model ----------------
   function automatic int mem_decode();
      int s = int'(mem[NB]) * CAP;
      for (int i = 0; i < NB; i++) s += $countones(mem[i]);
      return s % MODC;
   endfunction

   function automatic int exp_wrap(input int c);
      return (c == 0) ? 0 : (c - 1) / CAP;
   endfunction

   function automatic int exp_byte(input int c, input int addr);
      int r, k;
      if (c == 0) return 0;
      r = c - CAP * exp_wrap(c);
      for (int p = 0; p < NB; p++) begin
         if ((p ^ (p >> 1)) == addr) begin
            k = r - BW * p;
            if (k < 0) k = 0;
            if (k > BW) k = BW;
            return (1 << k) - 1;
         end
      end
      return -1;
   endfunction

   int model_count = 0, reqs_sent = 0, dones_seen = 0;
   bit prev_valid = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) prev_valid = 1'b0;
      else if (count_valid) begin
         if (!prev_valid) begin
            model_count = mem_decode();
            check(int'(count) == model_count, "R1 rebuilt count", int'(count), model_count);
         end else begin
            if (done) begin model_count = (model_count + 1) % MODC; dones_seen++; end
            check(int'(count) == model_count, "R6 count per clock", int'(count), model_count);
         end
         prev_valid = 1'b1;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic pulse_inc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); inc_req = 1'b1; reqs_sent++;
      end
      @(negedge clk); inc_req = 1'b0;
   endtask

   task automatic wait_idle();
      while (!(count_valid && dones_seen == reqs_sent && !busy)) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      reqs_sent = 0; dones_seen = 0;
      rst_n = 1'b1;
   endtask

   task automatic check_image(input int c, input string req);
      for (int a = 0; a < NB; a++)
         check(int'(mem[a]) == exp_byte(c, a), req, int'(mem[a]), exp_byte(c, a));
      check(int'(mem[NB]) == exp_wrap(c), "R4 wrap word", int'(mem[NB]), exp_wrap(c));
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      do_reset();
      // R1: reset state before scan finishes
      @(negedge clk);
      check(count_valid == 1'b0, "R1 valid low during scan", int'(count_valid), 0);
      check(busy == 1'b1, "R1 busy during scan", int'(busy), 1);
      wait_idle();
      check(int'(count) == 0, "R1 empty memory count", int'(count), 0);
      check(trace_c.size() == NB + 1, "R1 scan reads", trace_c.size(), NB + 1);
      for (int i = 0; i < NB + 1 && i < trace_c.size(); i++)
         check(trace_c[i] == 0 && trace_a[i] == i, "R1 scan order", trace_a[i], i);

      // R2/R3/R4: single increments through the first wrap
      for (int c = 1; c <= CAP + 1; c++) begin
         trace_c.delete(); trace_a.delete(); trace_d.delete();
         pulse_inc(1);
         wait_idle();
         check(int'(count) == c, "R6 count after increment", int'(count), c);
         check_image(c, c <= CAP ? "R2 Gray fill image" : "R4 image after wrap");
         if (c <= CAP)
            check(trace_c.size() == 1 && trace_c[0] == 1, "R3 single program", trace_c.size(), 1);
      end
      // R4: ordered wrap sequence
      check(trace_c.size() == NB + 3, "R4 wrap command count", trace_c.size(), NB + 3);
      if (trace_c.size() == NB + 3) begin
         check(trace_c[0] == 2 && trace_a[0] == NB, "R4 erase wrap first", trace_a[0], NB);
         check(trace_c[1] == 1 && trace_a[1] == NB && trace_d[1] == 1, "R4 program wrap", int'(trace_d[1]), 1);
         for (int i = 0; i < NB; i++)
            check(trace_c[2 + i] == 2 && trace_a[2 + i] < NB, "R4 byte erase", trace_c[2 + i], 2);
         check(trace_c[NB + 2] == 1 && trace_a[NB + 2] == 0 && trace_d[NB + 2] == 1,
               "R4 restart program", int'(trace_d[NB + 2]), 1);
      end
      for (int a = 0; a <= NB; a++)
         check(erase_cnt[a] == 1, "R4 one erase per location", erase_cnt[a], 1);

      // R7: burst of back-to-back requests
      pulse_inc(5);
      wait_idle();
      check(int'(count) == CAP + 6, "R7 burst served", int'(count), CAP + 6);
      check_image(CAP + 6, "R7 image after burst");

      // R5: corrupt the active byte, then restart with memory kept
      mem[0] = 8'h15;
      do_reset();
      wait_idle();
      check(int'(count) == CAP + 3, "R1 rebuild with bad byte", int'(count), CAP + 3);
      trace_c.delete(); trace_a.delete(); trace_d.delete();
      pulse_inc(1);
      wait_idle();
      check(trace_c.size() == 2 && trace_c[0] == 2 && trace_a[0] == 0,
            "R5 erase before repair", trace_c.size(), 2);
      check(int'(mem[0]) == 8'h0F, "R5 repaired byte", int'(mem[0]), 8'h0F);
      check(int'(count) == CAP + 4, "R5 count after repair", int'(count), CAP + 4);
      check(erase_cnt[0] == 2, "R5 extra erase on byte", erase_cnt[0], 2);

      // R7/R2: long run of varied bursts
      for (int b = 0; b < 63; b++) begin
         pulse_inc((b % 7) + 1);
         wait_idle();
      end
      cnt = CAP + 4 + 252;
      check(int'(count) == cnt, "R7 long run count", int'(count), cnt);
      check_image(cnt, "R2 long run image");

      // R7/R1: requests queued during the scan
      do_reset();
      pulse_inc(2);
      wait_idle();
      cnt = cnt + 2;
      check(int'(count) == cnt, "R7 queued during scan", int'(count), cnt);
      check_image(cnt, "R2 image after scan queue");
      for (int a = 1; a < NB; a++)
         check(erase_cnt[a] == exp_wrap(cnt), "R4 erase balance", erase_cnt[a], exp_wrap(cnt));
      check(erase_cnt[0] == exp_wrap(cnt) + 1, "R4 erase byte0", erase_cnt[0], exp_wrap(cnt) + 1);
      check(erase_cnt[NB] == exp_wrap(cnt), "R4 wrap erases", erase_cnt[NB], exp_wrap(cnt));

      check(clear_viol == 0, "R9 no bit cleared without erase", clear_viol, 0);
      check(multi_bit == 0, "R3 one bit per program", multi_bit, 0);
      check(bad_cmd == 0, "R8 legal commands", bad_cmd, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule